// File: doc/BRIEF.md
# Register File with Operand Forwarding Crossbar

This block holds the architectural integer registers of a small in-order core. It supplies the two source operands of each issuing instruction to a two-stage execution unit. A result comes back from the unit over a crossbar, which is a layer of multiplexers. That result goes straight to any operand port that names the same register in the same cycle, and it is also written into the register array.

The array commits a write one cycle after the result crosses. To cover that cycle, a late-forward stage holds the most recent crossbar write for one cycle and answers reads of that register. An instruction that issues one cycle after its producer's result was on the crossbar therefore gets the new value and does not wait.

A pending bit per register records which registers still have a result inside the pipeline. The block stalls an issue whose sources or destination are still pending, unless the crossbar delivers that register in the same cycle. An issue is accepted in a cycle when `iss_valid` is high and `iss_stall` is low. Its result is expected on the crossbar three cycles later: one read cycle and two execution stages.

Top module: `regset_xbar`

## Requirements
- R1: After reset every register reads as zero and no issue is stalled.
- R2: Register 0 always reads as zero, an accepted issue targeting it sets no pending state, and results addressed to it change nothing.
- R3: A result present on the crossbar in cycle t is returned by a read of that register in cycle t+2 or any later cycle, until the register is next written.
- R4: When a read port names the register that the crossbar carries in the same cycle, the operand equals the crossbar data, ahead of the late-forward stage and the array.
- R5: A read in cycle t+1 of a register written over the crossbar in cycle t returns the new value, not the previous array contents.
- R6: An accepted issue marks its destination pending, and a crossbar result for that register clears the mark. If both happen to the same register in one cycle, the mark stays set.
- R7: An issue stalls while either source register is pending and that register is not on the crossbar in the same cycle.
- R8: An issue stalls while its destination register is pending and not being cleared by the crossbar in the same cycle, so that two writes to one register are never in flight together.
- R9: The stall output is low in every cycle in which `iss_valid` is low.
- R10: A dependent instruction offered one cycle after its producer is stalled for exactly two cycles. The same instruction offered three, four or five cycles after its producer is never stalled, and every case yields the correct sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | An instruction is offered for issue this cycle |
| iss_dst | input | 6 | Destination register of the offered instruction |
| iss_src_a | input | 6 | First source register |
| iss_src_b | input | 6 | Second source register |
| iss_stall | output | 1 | Offered instruction must be held and offered again |
| opnd_a | output | 64 | First operand for the offered instruction |
| opnd_b | output | 64 | Second operand for the offered instruction |
| res_valid | input | 1 | The execution unit drives a result onto the crossbar |
| res_dst | input | 6 | Register the result is written to |
| res_data | input | 64 | Result value |

## Verification
The assertions assume that every crossbar result belongs to an accepted issue whose destination is still pending. They also assume it arrives exactly three cycles after that issue, so that no crossbar write reaches a register with nothing in flight. The bench meets this by generating results only from its own two-stage unit model, which receives the operands of each accepted issue. It never drives the result port on its own. Register values enter through immediate-load instructions that add an immediate to register 0.

// File: rtl/rsx_pkg.sv
package rsx_pkg;

    localparam int unsigned RSX_DATA_W = 64;
    localparam int unsigned RSX_NREGS  = 64;
    localparam int unsigned RSX_ADDR_W = $clog2(RSX_NREGS);
    localparam int unsigned RSX_NRD    = 2;

    typedef logic [RSX_DATA_W-1:0] data_t;
    typedef logic [RSX_ADDR_W-1:0] addr_t;

    // One write travelling over the crossbar or held in the late stage
    typedef struct packed {
        logic  valid;
        addr_t addr;
        data_t data;
    } wb_t;

    // A write matches a reader only if it is live and not aimed at register 0
    function automatic logic wb_hits(wb_t wb, addr_t a);
        return wb.valid && (wb.addr == a) && (a != '0);
    endfunction

endpackage

// File: rtl/rsx_array.sv
module rsx_array
    import rsx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wb_t   xbar_wb,
    input  addr_t rd_addr [RSX_NRD],
    output data_t rd_data [RSX_NRD],
    output wb_t   late_wb
);

    data_t mem_q [RSX_NREGS];

    // Late stage: the crossbar write of the previous cycle, dropped for reg 0
    always_ff @(posedge clk) begin
        if (rst) begin
            late_wb <= '0;
        end else begin
            late_wb.valid <= xbar_wb.valid && (xbar_wb.addr != '0);
            late_wb.addr  <= xbar_wb.addr;
            late_wb.data  <= xbar_wb.data;
        end
    end

    // Storage commits from the late stage, one cycle after the crossbar
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RSX_NREGS; i++) mem_q[i] <= '0;
        end else if (late_wb.valid) begin
            mem_q[late_wb.addr] <= late_wb.data;
        end
    end

    for (genvar p = 0; p < RSX_NRD; p++) begin : g_rd
        assign rd_data[p] = (rd_addr[p] == '0) ? '0 : mem_q[rd_addr[p]];
    end

    // R5
    late_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (xbar_wb.valid && xbar_wb.addr != '0) |=>
        (late_wb.valid && late_wb.data == $past(xbar_wb.data)));

    // R2
    late_r0_chk: assert property (@(posedge clk) disable iff (rst)
        late_wb.valid |-> (late_wb.addr != '0));

endmodule

// File: rtl/rsx_fwd.sv
module rsx_fwd
    import rsx_pkg::*;
(
    input  addr_t src,
    input  wb_t   xbar_wb,
    input  wb_t   late_wb,
    input  data_t arr_data,
    output data_t opnd,
    output logic  xbar_hit
);

    logic late_hit;

    assign xbar_hit = wb_hits(xbar_wb, src);
    assign late_hit = wb_hits(late_wb, src);

    // Crossbar first, then the late stage, then the array
    always_comb begin
        if (xbar_hit)      opnd = xbar_wb.data;
        else if (late_hit) opnd = late_wb.data;
        else               opnd = arr_data;
    end

endmodule

// File: rtl/rsx_score.sv
module rsx_score
    import rsx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  iss_valid,
    input  addr_t iss_dst,
    input  addr_t iss_src_a,
    input  addr_t iss_src_b,
    input  wb_t   xbar_wb,
    output logic  stall
);

    logic [RSX_NREGS-1:0] pend_q, pend_d;
    logic blk_a, blk_b, blk_d, accept;

    assign blk_a  = pend_q[iss_src_a] && !wb_hits(xbar_wb, iss_src_a);
    assign blk_b  = pend_q[iss_src_b] && !wb_hits(xbar_wb, iss_src_b);
    assign blk_d  = pend_q[iss_dst]   && !wb_hits(xbar_wb, iss_dst);
    assign stall  = iss_valid && (blk_a || blk_b || blk_d);
    assign accept = iss_valid && !stall;

    always_comb begin
        pend_d = pend_q;
        if (xbar_wb.valid) pend_d[xbar_wb.addr] = 1'b0;
        if (accept)        pend_d[iss_dst]      = 1'b1;
        pend_d[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    // R6
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && iss_dst != '0) |=> pend_q[$past(iss_dst)]);

    // R6
    pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (xbar_wb.valid && !(accept && iss_dst == xbar_wb.addr)) |=>
        !pend_q[$past(xbar_wb.addr)]);

    // R2
    pend_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_q[0]);

    // R9
    stall_qual_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> iss_valid);

    // R8
    res_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (xbar_wb.valid && xbar_wb.addr != '0) |-> pend_q[xbar_wb.addr]);

endmodule

// File: rtl/regset_xbar.sv
module regset_xbar
    import rsx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  iss_valid,
    input  logic [RSX_ADDR_W-1:0] iss_dst,
    input  logic [RSX_ADDR_W-1:0] iss_src_a,
    input  logic [RSX_ADDR_W-1:0] iss_src_b,
    output logic                  iss_stall,
    output logic [RSX_DATA_W-1:0] opnd_a,
    output logic [RSX_DATA_W-1:0] opnd_b,
    input  logic                  res_valid,
    input  logic [RSX_ADDR_W-1:0] res_dst,
    input  logic [RSX_DATA_W-1:0] res_data
);

    wb_t   xbar_wb, late_wb;
    addr_t rd_addr [RSX_NRD];
    data_t arr_data [RSX_NRD];
    data_t fwd_data [RSX_NRD];
    logic  xbar_hit [RSX_NRD];

    assign xbar_wb.valid = res_valid;
    assign xbar_wb.addr  = res_dst;
    assign xbar_wb.data  = res_data;

    assign rd_addr[0] = iss_src_a;
    assign rd_addr[1] = iss_src_b;

    rsx_array u_array (
        .clk     (clk),
        .rst     (rst),
        .xbar_wb (xbar_wb),
        .rd_addr (rd_addr),
        .rd_data (arr_data),
        .late_wb (late_wb)
    );

    for (genvar p = 0; p < RSX_NRD; p++) begin : g_port
        rsx_fwd u_fwd (
            .src      (rd_addr[p]),
            .xbar_wb  (xbar_wb),
            .late_wb  (late_wb),
            .arr_data (arr_data[p]),
            .opnd     (fwd_data[p]),
            .xbar_hit (xbar_hit[p])
        );
    end

    assign opnd_a = fwd_data[0];
    assign opnd_b = fwd_data[1];

    rsx_score u_score (
        .clk       (clk),
        .rst       (rst),
        .iss_valid (iss_valid),
        .iss_dst   (iss_dst),
        .iss_src_a (iss_src_a),
        .iss_src_b (iss_src_b),
        .xbar_wb   (xbar_wb),
        .stall     (iss_stall)
    );

    // R4
    bypass_a_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_dst == iss_src_a && iss_src_a != '0) |-> (opnd_a == res_data));

    // R4
    bypass_b_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_dst == iss_src_b && iss_src_b != '0) |-> (opnd_b == res_data));

    // R2
    zero_a_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_src_a == '0) |-> (opnd_a == '0));

    // R2
    zero_b_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_src_b == '0) |-> (opnd_b == '0));

endmodule

// File: tb/regset_xbar_tb_top.sv
module regset_xbar_tb_top;
    import rsx_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, iss_valid, iss_stall, res_valid;
    logic [5:0]  iss_dst, iss_src_a, iss_src_b, res_dst;
    logic [63:0] opnd_a, opnd_b, res_data;

    regset_xbar dut_i (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_dst(iss_dst),
        .iss_src_a(iss_src_a), .iss_src_b(iss_src_b), .iss_stall(iss_stall),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .res_valid(res_valid),
        .res_dst(res_dst), .res_data(res_data)
    );

    int n_vec = 0, n_bad = 0, stall_cnt = 0;
    logic [63:0] mreg [64];
    bit          mpend [64];
    bit          pv [3];
    logic [5:0]  pd [3];
    logic [63:0] px [3];
    logic [63:0] cur_imm, last_a;
    bit          acc;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock: inputs already driven after a falling edge
    task automatic cyc();
        bit          exp_stall;
        logic [63:0] ea, eb;
        logic [5:0]  ndst;
        logic [63:0] nval;
        bit          nv;
        res_valid = pv[2]; res_dst = pd[2]; res_data = px[2];
        #1;
        exp_stall = iss_valid && (
            (mpend[iss_src_a] && !(pv[2] && pd[2] == iss_src_a)) ||
            (mpend[iss_src_b] && !(pv[2] && pd[2] == iss_src_b)) ||
            (mpend[iss_dst]   && !(pv[2] && pd[2] == iss_dst)));
        chk(iss_stall == exp_stall, "R7/R8/R9 stall", 64'(iss_stall), 64'(exp_stall));
        ea = (pv[2] && pd[2] == iss_src_a && iss_src_a != 0) ? px[2] : mreg[iss_src_a];
        eb = (pv[2] && pd[2] == iss_src_b && iss_src_b != 0) ? px[2] : mreg[iss_src_b];
        acc = iss_valid && !exp_stall;
        if (iss_stall) stall_cnt++;
        if (acc) begin
            chk(opnd_a == ea, "R3/R4/R5 operand a", opnd_a, ea);
            chk(opnd_b == eb, "R3/R4/R5 operand b", opnd_b, eb);
        end
        last_a = opnd_a;
        nv = acc; ndst = iss_dst; nval = opnd_a + opnd_b + cur_imm;
        if (pv[2] && pd[2] != 0) begin
            mreg[pd[2]] = px[2];
            mpend[pd[2]] = 0;
        end
        if (acc && iss_dst != 0) mpend[iss_dst] = 1;
        pv[2] = pv[1]; pd[2] = pd[1]; px[2] = px[1];
        pv[1] = pv[0]; pd[1] = pd[0]; px[1] = px[0];
        pv[0] = nv;    pd[0] = ndst;  px[0] = nval;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        iss_valid = 0;
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic iss(logic [5:0] d, logic [5:0] a, logic [5:0] b, logic [63:0] imm);
        iss_valid = 1; iss_dst = d; iss_src_a = a; iss_src_b = b; cur_imm = imm;
        do cyc(); while (!acc);
        iss_valid = 0; cur_imm = 0;
    endtask

    // Chain of four dependent adds over five loaded registers
    task automatic chain(int gap, int exp_stalls, int tag);
        logic [63:0] v [6];
        logic [63:0] sum;
        int s0;
        sum = 0;
        for (int i = 1; i <= 5; i++) begin
            v[i] = 64'(tag) * 64'h0100_0000_0000_0001 + 64'(i * 7);
            sum += v[i];
            iss(6'(i), 0, 0, v[i]);
        end
        idle(5);
        s0 = stall_cnt;
        iss(10, 1, 2, 0);
        for (int k = 1; k <= 3; k++) begin
            idle(gap);
            iss(6'(10 + k), 6'(9 + k), 6'(k + 2), 0);
        end
        // R10
        chk(stall_cnt - s0 == exp_stalls, "R10 stall count", 64'(stall_cnt - s0), 64'(exp_stalls));
        idle(5);
        iss(0, 13, 0, 0);
        // R10, R3
        chk(last_a == sum, "R10 chain sum", last_a, sum);
    endtask

    initial begin
        int s0;
        for (int i = 0; i < 64; i++) begin mreg[i] = 0; mpend[i] = 0; end
        for (int i = 0; i < 3; i++) begin pv[i] = 0; pd[i] = 0; px[i] = 0; end
        iss_valid = 0; iss_dst = 0; iss_src_a = 0; iss_src_b = 0; cur_imm = 0;
        res_valid = 0; res_dst = 0; res_data = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: register 7 and 63 zero, no stall
        iss_valid = 1; iss_dst = 0; iss_src_a = 7; iss_src_b = 63;
        #1;
        chk(!iss_stall, "R1 stall after reset", 64'(iss_stall), 0);
        chk(opnd_a == 0 && opnd_b == 0, "R1 operands after reset", opnd_a | opnd_b, 0);
        iss_valid = 0;
        @(negedge clk);
        // R2: write to register 0 ignored
        iss(0, 0, 0, 64'd99);
        idle(5);
        iss(1, 0, 0, 0);
        chk(last_a == 0, "R2 reg0 reads zero", last_a, 0);
        idle(4);
        chain(0, 6, 1);   // back to back
        idle(4);
        chain(2, 0, 2);   // on the crossbar cycle
        idle(4);
        chain(3, 0, 3);   // one cycle late, late stage
        idle(4);
        chain(4, 0, 4);   // two cycles late, array
        idle(4);
        // R7 dependence on the second source
        s0 = stall_cnt;
        iss(20, 0, 0, 64'h55);
        iss(21, 0, 20, 64'h1);
        chk(stall_cnt - s0 == 2, "R7 src b stall count", 64'(stall_cnt - s0), 2);
        idle(5);
        // R8 two writes to one register
        s0 = stall_cnt;
        iss(30, 0, 0, 64'h11);
        iss(30, 0, 0, 64'h22);
        chk(stall_cnt - s0 == 2, "R8 dst stall count", 64'(stall_cnt - s0), 2);
        idle(5);
        iss(0, 30, 21, 0);
        chk(last_a == 64'h22, "R8 R6 final value", last_a, 64'h22);
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule